// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller sits in the always-on domain of a small microcontroller. It decides which clocks, oscillators, regulator modes and power switches are active. Software first sets three mode-select bits: regulator off, bypass switch on and regulator low current. It may also set per-group gate requests for peripheral and memory clocks. The CPU then pulses a wait indication, on a wait-for-interrupt or wait-for-event, and the controller enters the selected state: Sleep, one of two Deep-Sleep variants, or Power-Down.

An enabled wakeup event brings the block back to Run. The path back depends on how deep the state was. From Sleep the CPU clock is ungated at once. From Deep-Sleep the oscillators restart, and the clocks are ungated only after a stable indication. From Power-Down the core domain is switched back on and taken through a full reset sequence, and a status flag is set. The isolation toward the backup-domain registers is enabled at power-on and at every Power-Down entry. It stays enabled until software explicitly releases it.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After power-on reset, `core_rst_n` is held low for `RST_CYC` cycles, with all clocks gated and the three oscillator enables high. `iso_en` is 1 and `pd_flag` is 0. The block then enters Run: all clocks ungated, `core_pwr_en` high, regulator controls low.
- R2: A `wait_req` seen in Run selects the target. `cfg_reg_off`=1 gives Power-Down. Otherwise `cfg_bypass_on`=1 gives Deep-Sleep variant 2. Otherwise `cfg_reg_lowcur`=1 gives Deep-Sleep variant 1. With all three bits at 0 it gives Sleep. The outputs show the new state right after the clock edge that samples the request.
- R3: In Sleep, `cpu_clk_en` is 0. Each bit `grp_clk_en[i]` equals the inverse of `cfg_gate_req[i]` as captured at entry. Oscillators stay enabled.
- R4: In Sleep, an enabled wakeup event returns the block to Run on the next clock edge, with oscillator enables unchanged.
- R5: In Deep-Sleep, all clocks are gated and `hsi_en`, `hse_en` and `pll_en` are 0. `reg_lowcur`=1 in variant 1 and `bypass_on`=1 in variant 2; the two are never high together.
- R6: On wakeup from Deep-Sleep, the oscillators are enabled first while all clocks stay gated. Only when `osc_stable` is high does the next edge return the block to Run.
- R7: In Power-Down, `core_pwr_en` and `core_rst_n` are 0, all clocks and oscillators are off, regulator controls are 0, and `iso_en` is 1.
- R8: On wakeup from Power-Down, `core_pwr_en` rises with `core_rst_n` still low. After `core_pwr_good`, a reset hold of `RST_CYC` cycles with oscillators on and `osc_stable` high precedes Run. On reaching Run, `pd_flag` is set to 1. A `pd_flag_clr` pulse clears it.
- R9: `iso_en` stays 1 after a resume from reset or Power-Down. It falls only after an `iso_release` pulse in Run; a pulse during the reset hold is ignored.
- R10: If an enabled wakeup event is pending when `wait_req` arrives, entry is aborted and every output keeps its Run value.
- R11: Wakeup events whose `wake_en` bit is 0 have no effect in any low-power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| cfg_reg_off | input | 1 | Mode select: switch the core domain off |
| cfg_bypass_on | input | 1 | Mode select: use the bypass switch |
| cfg_reg_lowcur | input | 1 | Mode select: regulator low-current mode |
| cfg_gate_req | input | NUM_GRP | Per-group clock gate request for Sleep |
| wait_req | input | 1 | Wait-for-interrupt/event pulse from the CPU |
| wake_evt | input | NUM_WAKE | Wakeup event lines |
| wake_en | input | NUM_WAKE | Wakeup event enables |
| osc_stable | input | 1 | Oscillators stable and PLL locked |
| core_pwr_good | input | 1 | Core domain supply is up |
| iso_release | input | 1 | Software pulse releasing backup isolation |
| pd_flag_clr | input | 1 | Software pulse clearing the Power-Down flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| grp_clk_en | output | NUM_GRP | Peripheral/memory group clock enables |
| hsi_en | output | 1 | Internal oscillator enable |
| hse_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | PLL enable |
| reg_lowcur | output | 1 | Regulator low-current mode |
| bypass_on | output | 1 | Bypass switch on |
| core_pwr_en | output | 1 | Core domain power switch |
| core_rst_n | output | 1 | Core domain reset, active low |
| iso_en | output | 1 | Isolation toward backup registers |
| pd_flag | output | 1 | Last low-power state was Power-Down |

## Verification
The bench checks the decode priority when several mode bits are set together. A wrong order would land in Deep-Sleep instead of Power-Down, or pick the wrong regulator control. It holds `osc_stable` low after a Deep-Sleep wakeup and expects the clocks to stay gated. A design that skips this handshake would ungate the CPU on unstable clocks. It sends wakeup events that are already pending at the wait request, and events on disabled lines. A design that mishandles either would sleep through a pending interrupt or wake on a masked source. It also pulses the isolation release during the post-Power-Down reset hold. Here a faulty design would drop isolation before the core domain is out of reset.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_SLEEP = 3'd1,
      ST_DEEP  = 3'd2,
      ST_OSCW  = 3'd3,
      ST_PDOWN = 3'd4,
      ST_PWRW  = 3'd5,
      ST_RSTH  = 3'd6
   } pwr_state_e;

   typedef enum logic [1:0] {
      DS_NONE   = 2'd0,
      DS_LOWCUR = 2'd1,
      DS_BYPASS = 2'd2
   } ds_var_e;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
   parameter int NUM_WAKE = 4
) (
   input  logic [NUM_WAKE-1:0] wake_evt,
   input  logic [NUM_WAKE-1:0] wake_en,
   output logic                pend
);
   logic [NUM_WAKE-1:0] masked;
   for (genvar i = 0; i < NUM_WAKE; i++) begin : g_mask
      assign masked[i] = wake_evt[i] & wake_en[i];
   end
   assign pend = |masked;
endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
   parameter int RST_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

   logic [CW-1:0] cnt_q;

   assign done = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (!done)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
   import pwr_seq_pkg::*;
#(
   parameter int NUM_GRP = 3
) (
   input  pwr_state_e         st,
   input  ds_var_e            dsv,
   input  logic [NUM_GRP-1:0] gate_lat,
   output logic               cpu_clk_en,
   output logic [NUM_GRP-1:0] grp_clk_en,
   output logic               osc_on,
   output logic               reg_lowcur,
   output logic               bypass_on,
   output logic               core_pwr_en,
   output logic               core_rst_n
);
   logic run_s, sleep_s;

   assign run_s   = (st == ST_RUN);
   assign sleep_s = (st == ST_SLEEP);

   assign cpu_clk_en  = run_s;
   assign osc_on      = run_s | sleep_s | (st == ST_OSCW) | (st == ST_RSTH);
   assign reg_lowcur  = (st == ST_DEEP) && (dsv == DS_LOWCUR);
   assign bypass_on   = (st == ST_DEEP) && (dsv == DS_BYPASS);
   assign core_pwr_en = (st != ST_PDOWN);
   assign core_rst_n  = !((st == ST_PDOWN) || (st == ST_PWRW) || (st == ST_RSTH));

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign grp_clk_en[g] = run_s | (sleep_s & ~gate_lat[g]);
   end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int NUM_GRP  = 3,
   parameter int NUM_WAKE = 4,
   parameter int RST_CYC  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_reg_off,
   input  logic                cfg_bypass_on,
   input  logic                cfg_reg_lowcur,
   input  logic [NUM_GRP-1:0]  cfg_gate_req,
   input  logic                wait_req,
   input  logic [NUM_WAKE-1:0] wake_evt,
   input  logic [NUM_WAKE-1:0] wake_en,
   input  logic                osc_stable,
   input  logic                core_pwr_good,
   input  logic                iso_release,
   input  logic                pd_flag_clr,
   output logic                cpu_clk_en,
   output logic [NUM_GRP-1:0]  grp_clk_en,
   output logic                hsi_en,
   output logic                hse_en,
   output logic                pll_en,
   output logic                reg_lowcur,
   output logic                bypass_on,
   output logic                core_pwr_en,
   output logic                core_rst_n,
   output logic                iso_en,
   output logic                pd_flag
);
   if (NUM_GRP < 1 || NUM_WAKE < 1) begin : g_bad_width
      $error("pwr_seq_ctrl: NUM_GRP and NUM_WAKE must be at least 1");
   end
   if (RST_CYC < 2) begin : g_bad_rst
      $error("pwr_seq_ctrl: RST_CYC must be at least 2");
   end

   pwr_state_e         st_q, st_d, tgt;
   ds_var_e            dsv_q, dsv_d;
   logic [NUM_GRP-1:0] gate_q;
   logic               pend, rst_done, osc_on;
   logic               iso_q, from_pd_q, pdf_q;
   logic               leave_run, leave_rsth;

   pwr_wake_detect #(.NUM_WAKE(NUM_WAKE)) u_wake (
      .wake_evt (wake_evt),
      .wake_en  (wake_en),
      .pend     (pend)
   );

   pwr_rst_timer #(.RST_CYC(RST_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == ST_RSTH),
      .done  (rst_done)
   );

   always_comb begin
      if (cfg_reg_off)                        tgt = ST_PDOWN;
      else if (cfg_bypass_on || cfg_reg_lowcur) tgt = ST_DEEP;
      else                                    tgt = ST_SLEEP;
      if (cfg_bypass_on)       dsv_d = DS_BYPASS;
      else if (cfg_reg_lowcur) dsv_d = DS_LOWCUR;
      else                     dsv_d = DS_NONE;
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN:   if (wait_req && !pend)        st_d = tgt;
         ST_SLEEP: if (pend)                     st_d = ST_RUN;
         ST_DEEP:  if (pend)                     st_d = ST_OSCW;
         ST_OSCW:  if (osc_stable)               st_d = ST_RUN;
         ST_PDOWN: if (pend)                     st_d = ST_PWRW;
         ST_PWRW:  if (core_pwr_good)            st_d = ST_RSTH;
         ST_RSTH:  if (rst_done && osc_stable)   st_d = ST_RUN;
         default:                                st_d = ST_RSTH;
      endcase
   end

   assign leave_run  = (st_q == ST_RUN)  && (st_d != ST_RUN);
   assign leave_rsth = (st_q == ST_RSTH) && (st_d == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_RSTH;
         dsv_q     <= DS_NONE;
         gate_q    <= '0;
         iso_q     <= 1'b1;
         from_pd_q <= 1'b0;
         pdf_q     <= 1'b0;
      end else begin
         st_q <= st_d;
         if (leave_run) begin
            dsv_q  <= dsv_d;
            gate_q <= cfg_gate_req;
         end
         if (st_d == ST_PDOWN)                    iso_q <= 1'b1;
         else if (st_q == ST_RUN && iso_release)  iso_q <= 1'b0;
         if (st_d == ST_PDOWN)                    from_pd_q <= 1'b1;
         else if (leave_rsth)                     from_pd_q <= 1'b0;
         if (leave_rsth && from_pd_q)             pdf_q <= 1'b1;
         else if (pd_flag_clr)                    pdf_q <= 1'b0;
      end
   end

   pwr_out_decode #(.NUM_GRP(NUM_GRP)) u_dec (
      .st          (st_q),
      .dsv         (dsv_q),
      .gate_lat    (gate_q),
      .cpu_clk_en  (cpu_clk_en),
      .grp_clk_en  (grp_clk_en),
      .osc_on      (osc_on),
      .reg_lowcur  (reg_lowcur),
      .bypass_on   (bypass_on),
      .core_pwr_en (core_pwr_en),
      .core_rst_n  (core_rst_n)
   );

   assign hsi_en  = osc_on;
   assign hse_en  = osc_on;
   assign pll_en  = osc_on;
   assign iso_en  = iso_q;
   assign pd_flag = pdf_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
   parameter int NUM_GRP = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iso_release,
   input logic               cpu_clk_en,
   input logic [NUM_GRP-1:0] grp_clk_en,
   input logic               hsi_en,
   input logic               reg_lowcur,
   input logic               bypass_on,
   input logic               core_pwr_en,
   input logic               core_rst_n,
   input logic               iso_en,
   input logic               pd_flag
);
   p_iso_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !core_pwr_en |-> iso_en);

   p_clk_needs_reset_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> (core_rst_n && core_pwr_en));

   p_no_clk_without_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !hsi_en |-> (!cpu_clk_en && grp_clk_en == '0));

   p_one_current_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_lowcur && bypass_on));

   p_iso_falls_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en) |-> $past(iso_release));

   p_flag_with_reset_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_flag) |-> $rose(core_rst_n));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NUM_GRP(NUM_GRP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .iso_release (iso_release),
   .cpu_clk_en  (cpu_clk_en),
   .grp_clk_en  (grp_clk_en),
   .hsi_en      (hsi_en),
   .reg_lowcur  (reg_lowcur),
   .bypass_on   (bypass_on),
   .core_pwr_en (core_pwr_en),
   .core_rst_n  (core_rst_n),
   .iso_en      (iso_en),
   .pd_flag     (pd_flag)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NG = 3;
   localparam int NW = 4;
   localparam int RC = 8;

   localparam int M_RUN = 0, M_SLEEP = 1, M_DEEP = 2, M_OSCW = 3,
                  M_PD = 4, M_PWRW = 5, M_RSTH = 6;

   logic clk = 0, rst_n = 0;
   logic cfg_reg_off = 0, cfg_bypass_on = 0, cfg_reg_lowcur = 0;
   logic [NG-1:0] cfg_gate_req = '0;
   logic wait_req = 0;
   logic [NW-1:0] wake_evt = '0, wake_en = '0;
   logic osc_stable = 1, core_pwr_good = 1, iso_release = 0, pd_flag_clr = 0;
   logic cpu_clk_en, hsi_en, hse_en, pll_en, reg_lowcur, bypass_on;
   logic core_pwr_en, core_rst_n, iso_en, pd_flag;
   logic [NG-1:0] grp_clk_en;

   int total = 0, bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_seq_ctrl #(.NUM_GRP(NG), .NUM_WAKE(NW), .RST_CYC(RC)) dut (.*);

   wire [NG+7:0] obs = {cpu_clk_en, grp_clk_en, hsi_en, hse_en, pll_en,
                        reg_lowcur, bypass_on, core_pwr_en, core_rst_n};

   function automatic logic [NG+7:0] exp_out(int m, logic [NG-1:0] gate, int dv);
      logic run, osc, pwr, rstn;
      logic [NG-1:0] g;
      run  = (m == M_RUN);
      osc  = (m == M_RUN) || (m == M_SLEEP) || (m == M_OSCW) || (m == M_RSTH);
      pwr  = (m != M_PD);
      rstn = !((m == M_PD) || (m == M_PWRW) || (m == M_RSTH));
      g    = run ? '1 : ((m == M_SLEEP) ? ~gate : '0);
      return {run, g, osc, osc, osc, (m == M_DEEP && dv == 1),
              (m == M_DEEP && dv == 2), pwr, rstn};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic enter(logic off, logic byp, logic lc, logic [NG-1:0] gate);
      cfg_reg_off = off; cfg_bypass_on = byp; cfg_reg_lowcur = lc;
      cfg_gate_req = gate; wait_req = 1;
      tick();
      wait_req = 0; cfg_reg_off = 0; cfg_bypass_on = 0; cfg_reg_lowcur = 0;
      cfg_gate_req = '0;
   endtask

   initial begin
      int unused;
      unused = $urandom(32'd4711);
      @(negedge clk);
      tick(3);
      chk("R1 reset outputs", 32'(obs), 32'(exp_out(M_RSTH, '0, 0)));
      chk("R1 reset iso", 32'(iso_en), 1);
      chk("R1 reset flag", 32'(pd_flag), 0);
      rst_n = 1;
      tick(RC - 1);
      chk("R1 reset hold length", 32'(core_rst_n), 0);
      tick();
      chk("R1 run after reset", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
      chk("R9 iso kept after reset", 32'(iso_en), 1);
      iso_release = 1; tick(); iso_release = 0;
      chk("R9 iso released in run", 32'(iso_en), 0);

      // Sleep directed
      wake_en = 4'b0010;
      enter(0, 0, 0, 3'b101);
      chk("R2 R3 sleep outputs", 32'(obs), 32'(exp_out(M_SLEEP, 3'b101, 0)));
      wake_evt = 4'b1101; tick(2);
      chk("R11 disabled wake in sleep", 32'(obs), 32'(exp_out(M_SLEEP, 3'b101, 0)));
      wake_evt = 4'b0010; tick();
      chk("R4 sleep wake", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
      // Abort with pending event still present
      enter(0, 0, 1, '0);
      chk("R10 abort on pending", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
      wake_evt = '0;

      // Deep-Sleep variant 1 with oscillator handshake
      enter(0, 0, 1, '0);
      chk("R5 deep variant1", 32'(obs), 32'(exp_out(M_DEEP, '0, 1)));
      osc_stable = 0;
      wake_evt = 4'b0001; tick();
      chk("R11 disabled wake in deep", 32'(obs), 32'(exp_out(M_DEEP, '0, 1)));
      wake_evt = 4'b0010; tick();
      chk("R6 osc restart first", 32'(obs), 32'(exp_out(M_OSCW, '0, 0)));
      tick(3);
      chk("R6 clocks gated until stable", 32'(obs), 32'(exp_out(M_OSCW, '0, 0)));
      osc_stable = 1; tick();
      chk("R6 run after stable", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
      wake_evt = '0;

      // Priority: bypass and low-current together pick variant 2
      enter(0, 1, 1, '0);
      chk("R2 R5 bypass beats lowcur", 32'(obs), 32'(exp_out(M_DEEP, '0, 2)));
      wake_evt = 4'b0010; tick(); tick();
      chk("R6 wake variant2", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
      wake_evt = '0;

      // Power-Down, all bits set: regulator-off wins
      enter(1, 1, 1, 3'b111);
      chk("R2 R7 power-down outputs", 32'(obs), 32'(exp_out(M_PD, '0, 0)));
      chk("R7 iso in power-down", 32'(iso_en), 1);
      core_pwr_good = 0; osc_stable = 0;
      wake_evt = 4'b0100; tick(2);
      chk("R11 disabled wake in power-down", 32'(obs), 32'(exp_out(M_PD, '0, 0)));
      wake_evt = 4'b0010; tick();
      chk("R8 power switch first", 32'(obs), 32'(exp_out(M_PWRW, '0, 0)));
      wake_evt = '0; tick(2);
      chk("R8 wait for supply", 32'(obs), 32'(exp_out(M_PWRW, '0, 0)));
      core_pwr_good = 1; osc_stable = 1; tick();
      chk("R8 reset hold", 32'(obs), 32'(exp_out(M_RSTH, '0, 0)));
      iso_release = 1; tick(); iso_release = 0;
      chk("R9 release ignored in reset hold", 32'(iso_en), 1);
      tick(RC - 2);
      chk("R8 reset hold length", 32'(core_rst_n), 0);
      tick();
      chk("R8 run after power-down", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
      chk("R8 flag set", 32'(pd_flag), 1);
      chk("R9 iso kept after power-down", 32'(iso_en), 1);
      pd_flag_clr = 1; tick(); pd_flag_clr = 0;
      chk("R8 flag cleared", 32'(pd_flag), 0);
      iso_release = 1; tick(); iso_release = 0;
      chk("R9 iso released", 32'(iso_en), 0);

      // Constrained random Sleep / Deep-Sleep rounds
      for (int it = 0; it < 40; it++) begin
         int kind, dv, idx;
         logic [NG-1:0] gate;
         logic [NW-1:0] en;
         kind = int'($urandom % 3);
         gate = NG'($urandom);
         idx  = int'($urandom % NW);
         en   = NW'($urandom) | (NW'(1) << idx);
         wake_en = en;
         dv = (kind == 2) ? 2 : ((kind == 1) ? 1 : 0);
         if ($urandom % 4 == 0) begin
            wake_evt = NW'(1) << idx;
            enter(0, kind == 2, kind == 1, gate);
            chk("R10 random abort", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
            wake_evt = '0;
         end else begin
            enter(0, kind == 2, kind == 1, gate);
            chk("R2 random entry", 32'(obs),
                32'(exp_out(kind == 0 ? M_SLEEP : M_DEEP, gate, dv)));
            wake_evt = ~en; tick();
            chk("R11 random masked wake", 32'(obs),
                32'(exp_out(kind == 0 ? M_SLEEP : M_DEEP, gate, dv)));
            if (kind == 0) begin
               wake_evt = NW'(1) << idx; tick();
               chk("R4 random sleep wake", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
            end else begin
               int d;
               osc_stable = 0;
               wake_evt = NW'(1) << idx; tick();
               d = int'($urandom % 4);
               tick(d);
               chk("R6 random osc wait", 32'(obs), 32'(exp_out(M_OSCW, '0, 0)));
               osc_stable = 1; tick();
               chk("R6 random resume", 32'(obs), 32'(exp_out(M_RUN, '0, 0)));
            end
            wake_evt = '0;
         end
      end

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule